// File: doc/BRIEF.md
# Buffer Watermark Encoder with Pause Hysteresis

This block turns byte-valued buffer thresholds into a compact 9-bit watermark code. It also uses two of those codes to drive a pause (flow-control) request for one port. A code uses one of two ranges, chosen by bit 8. With bit 8 clear, the low eight bits count cells one by one. With bit 8 set, each step of the low eight bits stands for sixteen cells. Values too large for the coarse range saturate at the top code and never wrap.

The pause request follows a live occupancy count, given in cells, with hysteresis. It rises once occupancy reaches the decoded start threshold. It stays up until occupancy falls to or below the decoded stop threshold. It is forced low while the block is disabled. The block also derives two tail-drop codes from a shared buffer size: one for each port and one for the total. The codes are combinational; the pause request is a registered output.

Top module: `wm_pause_ctrl`

## Requirements
- R1: A byte threshold becomes a cell count by floor division by CELL_BYTES (default 64), so any remainder bytes are dropped.
- R2: For a cell count below 256, the code has bit 8 clear and bits 7:0 equal to the cell count.
- R3: For a cell count from 256 to 4095, the code has bit 8 set and bits 7:0 equal to floor(cells/16).
- R4: For a cell count of 4096 or more, the code saturates at 9'h1FF.
- R5: Before any comparison with occupancy, a code is turned back into cells: low8×16 when bit 8 is set, otherwise low8. The pause request switches at these decoded values, even when they differ from the exact byte thresholds.
- R6: While enabled, pause_req_o goes high in the clock cycle after occupancy becomes greater than or equal to the decoded start threshold.
- R7: While enabled, pause_req_o does not change while occupancy is above the decoded stop threshold and below the decoded start threshold.
- R8: While enabled, pause_req_o goes low in the clock cycle after occupancy becomes less than or equal to the decoded stop threshold, unless the start condition also holds; the start condition takes priority.
- R9: While enable_i is low, pause_req_o is low from the next clock edge on, whatever the occupancy.
- R10: port_drop_code_o is the code of (shared_bytes_i / NUM_PORTS) + 1 bytes, using integer division.
- R11: total_drop_code_o is the code of shared_bytes_i.
- R12: While rst_n is low, pause_req_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Enables the pause request |
| stop_bytes_i | input | BYTE_W | Pause stop threshold, in bytes |
| start_bytes_i | input | BYTE_W | Pause start threshold, in bytes |
| shared_bytes_i | input | BYTE_W | Shared buffer size, in bytes |
| occ_cells_i | input | OCC_W | Current buffer occupancy, in cells |
| stop_code_o | output | 9 | Encoded stop threshold |
| start_code_o | output | 9 | Encoded start threshold |
| port_drop_code_o | output | 9 | Encoded tail-drop threshold for one port |
| total_drop_code_o | output | 9 | Encoded total tail-drop threshold |
| pause_req_o | output | 1 | Pause request with hysteresis |

## Verification
The hysteresis assertions assume that the threshold and occupancy inputs hold steady between clock edges and carry known values from the first edge on. The stimulus changes every input only on the falling clock edge and sets all of them before time zero. The encoder's saturation check assumes the byte inputs are never unknown, and it is skipped whenever they are. The stimulus also sweeps occupancy slowly across both thresholds, and moves it back and forth between them, so every cause of a change in the request is tied to a single input step.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int WM_W     = 9;
  localparam int FINE_LIM = 256;
  localparam int COARSE_SH = 4;

  typedef logic [WM_W-1:0] wm_code_t;

  // cell count -> two-range watermark code (saturating)
  function automatic wm_code_t wm_from_cells(input logic [31:0] cells);
    logic [31:0] q;
    q = cells >> COARSE_SH;
    if (cells < 32'(FINE_LIM)) return {1'b0, cells[7:0]};
    if (q >= 32'(FINE_LIM))    return {1'b1, 8'hFF};
    return {1'b1, q[7:0]};
  endfunction

  // watermark code -> cell count used for comparison
  function automatic logic [31:0] wm_to_cells(input wm_code_t c);
    if (c[WM_W-1]) return 32'(c[7:0]) << COARSE_SH;
    return 32'(c[7:0]);
  endfunction
endpackage

// File: rtl/wm_encoder.sv
module wm_encoder
  import wm_pkg::*;
#(
  parameter int IN_W       = 24,
  parameter int CELL_BYTES = 64
) (
  input  logic [IN_W-1:0] bytes_i,
  output wm_code_t        code_o
);
  localparam bit POW2     = (CELL_BYTES & (CELL_BYTES - 1)) == 0;
  localparam int CELL_SH  = $clog2(CELL_BYTES);

  logic [IN_W-1:0] cells;

  generate
    if (POW2) begin : g_shift
      assign cells = bytes_i >> CELL_SH;
    end else begin : g_div
      assign cells = bytes_i / IN_W'(CELL_BYTES);
    end
  endgenerate

  assign code_o = wm_from_cells(32'(cells));

  always_comb begin
    if (!$isunknown(bytes_i)) begin
      if (32'(cells) >= 32'd4096) begin
        p_saturate_r4: assert (code_o == 9'h1FF);
      end
      if (32'(cells) < 32'd256) begin
        p_fine_range_r2: assert (code_o[8] == 1'b0);
      end
    end
  end
endmodule

// File: rtl/wm_pause_hyst.sv
module wm_pause_hyst
  import wm_pkg::*;
#(
  parameter int OCC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [OCC_W-1:0] occ_i,
  input  wm_code_t         start_code_i,
  input  wm_code_t         stop_code_i,
  output logic             pause_o
);
  logic [31:0] start_cells, stop_cells;
  logic        hit_start, hit_stop;

  assign start_cells = wm_to_cells(start_code_i);
  assign stop_cells  = wm_to_cells(stop_code_i);
  assign hit_start   = 32'(occ_i) >= start_cells;
  assign hit_stop    = 32'(occ_i) <= stop_cells;

  always_ff @(posedge clk) begin
    if (!rst_n)         pause_o <= 1'b0;
    else if (!en_i)     pause_o <= 1'b0;
    else if (hit_start) pause_o <= 1'b1;
    else if (hit_stop)  pause_o <= 1'b0;
  end

  p_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_o) |-> $past(en_i && hit_start));
  p_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pause_o) |-> $past(!en_i || (hit_stop && !hit_start)));
  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !hit_start && !hit_stop) |=> $stable(pause_o));
  p_off_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pause_o);
endmodule

// File: rtl/wm_pause_ctrl.sv
module wm_pause_ctrl
  import wm_pkg::*;
#(
  parameter int BYTE_W     = 24,
  parameter int OCC_W      = 16,
  parameter int CELL_BYTES = 64,
  parameter int NUM_PORTS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [BYTE_W-1:0] stop_bytes_i,
  input  logic [BYTE_W-1:0] start_bytes_i,
  input  logic [BYTE_W-1:0] shared_bytes_i,
  input  logic [OCC_W-1:0]  occ_cells_i,
  output logic [8:0]        stop_code_o,
  output logic [8:0]        start_code_o,
  output logic [8:0]        port_drop_code_o,
  output logic [8:0]        total_drop_code_o,
  output logic              pause_req_o
);
  localparam int  EXT_W     = BYTE_W + 1;
  localparam int  N_ENC     = 4;
  localparam bit  PORT_POW2 = (NUM_PORTS & (NUM_PORTS - 1)) == 0;
  localparam int  PORT_SH   = $clog2(NUM_PORTS);

  logic [BYTE_W-1:0] share_div;
  logic [EXT_W-1:0]  share_port;
  logic [EXT_W-1:0]  enc_in  [N_ENC];
  wm_code_t          enc_out [N_ENC];

  generate
    if (PORT_POW2) begin : g_pshift
      assign share_div = shared_bytes_i >> PORT_SH;
    end else begin : g_pdiv
      assign share_div = shared_bytes_i / BYTE_W'(NUM_PORTS);
    end
  endgenerate

  assign share_port = EXT_W'(share_div) + EXT_W'(1);

  assign enc_in[0] = EXT_W'(stop_bytes_i);
  assign enc_in[1] = EXT_W'(start_bytes_i);
  assign enc_in[2] = share_port;
  assign enc_in[3] = EXT_W'(shared_bytes_i);

  generate
    for (genvar gi = 0; gi < N_ENC; gi++) begin : g_enc
      wm_encoder #(.IN_W(EXT_W), .CELL_BYTES(CELL_BYTES)) u_enc (
        .bytes_i (enc_in[gi]),
        .code_o  (enc_out[gi])
      );
    end
  endgenerate

  assign stop_code_o       = enc_out[0];
  assign start_code_o      = enc_out[1];
  assign port_drop_code_o  = enc_out[2];
  assign total_drop_code_o = enc_out[3];

  wm_pause_hyst #(.OCC_W(OCC_W)) u_hyst (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (enable_i),
    .occ_i        (occ_cells_i),
    .start_code_i (enc_out[1]),
    .stop_code_i  (enc_out[0]),
    .pause_o      (pause_req_o)
  );

  p_reset_low_r12: assert property (@(posedge clk)
    !rst_n |=> !pause_req_o);
endmodule

// File: tb/wm_pause_ctrl_tb.sv
module wm_pause_ctrl_tb_top;
  localparam int BW = 24;
  localparam int OW = 16;
  localparam int CB = 64;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [BW-1:0] stop_b = BW'(4 * 1518);
  logic [BW-1:0] start_b = BW'(6 * 1518);
  logic [BW-1:0] shared_b = BW'(200000);
  logic [OW-1:0] occ = '0;
  logic [8:0]    stop_c, start_c, pdrop_c, tdrop_c;
  logic          pause;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  wm_pause_ctrl #(.BYTE_W(BW), .OCC_W(OW), .CELL_BYTES(CB), .NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(en),
    .stop_bytes_i(stop_b), .start_bytes_i(start_b), .shared_bytes_i(shared_b),
    .occ_cells_i(occ),
    .stop_code_o(stop_c), .start_code_o(start_c),
    .port_drop_code_o(pdrop_c), .total_drop_code_o(tdrop_c),
    .pause_req_o(pause)
  );

  function automatic int ref_code(longint b);
    longint c = b / CB;
    if (c < 256) return int'(c);
    if (c / 16 > 255) return 511;
    return 256 + int'(c / 16);
  endfunction

  function automatic int ref_cells(int code);
    return (code >= 256) ? (code - 256) * 16 : code;
  endfunction

  function automatic string range_tag(longint b);
    longint c = b / CB;
    if (c < 256 && (b % CB) != 0) return "R1";
    if (c < 256) return "R2";
    if (c < 4096) return "R3";
    return "R4";
  endfunction

  // behavioural reference of the request, advanced each rising edge
  bit    m_pause = 1'b0;
  string m_tag = "R12";
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pause = 1'b0;
      m_tag = "R12";
    end else begin
      int  s, p;
      bit  coarse, nxt;
      s = ref_cells(ref_code(longint'(start_b)));
      p = ref_cells(ref_code(longint'(stop_b)));
      coarse = ref_code(longint'(start_b)) >= 256 || ref_code(longint'(stop_b)) >= 256;
      if (!en) nxt = 1'b0;
      else if (int'(occ) >= s) nxt = 1'b1;
      else if (int'(occ) <= p) nxt = 1'b0;
      else nxt = m_pause;
      if (!en) m_tag = "R9";
      else if (nxt && !m_pause) m_tag = coarse ? "R5" : "R6";
      else if (!nxt && m_pause) m_tag = coarse ? "R5" : "R8";
      else m_tag = "R7";
      m_pause = nxt;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(logic e, int o, int sp, int st, int sh);
    @(negedge clk);
    chk(m_tag, 32'(pause), 32'(m_pause));
    en = e; occ = OW'(o); stop_b = BW'(sp); start_b = BW'(st); shared_b = BW'(sh);
    #1;
    chk(range_tag(longint'(sp)), 32'(stop_c), 32'(ref_code(longint'(sp))));
    chk(range_tag(longint'(st)), 32'(start_c), 32'(ref_code(longint'(st))));
    chk("R10", 32'(pdrop_c), 32'(ref_code(longint'(sh / NP + 1))));
    chk("R11", 32'(tdrop_c), 32'(ref_code(longint'(sh))));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sp = 4 * 1518, st = 6 * 1518;
    // R12 reset, occupancy high while in reset
    repeat (3) cyc(1'b1, 500, sp, st, 200000);
    rst_n = 1'b1;
    // R6/R8/R7 fine-grain ramp up and down
    for (int i = 0; i <= 200; i++) cyc(1'b1, i, sp, st, 200000);
    for (int i = 200; i >= 0; i--) cyc(1'b1, i, sp, st, 200000);
    // R7 no chatter between thresholds
    cyc(1'b1, 150, sp, st, 200000);
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1, 100, sp, st, 200000);
      cyc(1'b1, 130, sp, st, 200000);
    end
    cyc(1'b1, 94, sp, st, 200000);
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1, 130, sp, st, 200000);
      cyc(1'b1, 100, sp, st, 200000);
    end
    // R9 disable while paused, then occupancy high while disabled
    cyc(1'b1, 300, sp, st, 200000);
    cyc(1'b0, 300, sp, st, 200000);
    cyc(1'b0, 1000, sp, st, 200000);
    cyc(1'b0, 1000, sp, st, 200000);
    cyc(1'b1, 0, sp, st, 200000);
    // R1..R4 encode boundaries at 255, 256, 4095, 4096+ cells
    cyc(1'b0, 0, 255 * 64, 255 * 64 + 63, 0);
    cyc(1'b0, 0, 256 * 64, 256 * 64 - 1, 16384 * 8);
    cyc(1'b0, 0, 4079 * 64, 4080 * 64, 3);
    cyc(1'b0, 0, 4095 * 64, 4096 * 64, 4095 * 64);
    cyc(1'b0, 0, 4111 * 64 + 5, (1 << 24) - 1, (1 << 24) - 1);
    cyc(1'b0, 0, 17, 300 * 64 + 10, 4096 * 64 * 8);
    // R5 coarse thresholds: start decodes to 288, stop to 256
    cyc(1'b1, 250, 260 * 64, 300 * 64, 200000);
    for (int i = 250; i <= 300; i++) cyc(1'b1, i, 260 * 64, 300 * 64, 200000);
    for (int i = 300; i >= 240; i--) cyc(1'b1, i, 260 * 64, 300 * 64, 200000);
    // R8 priority: start at or below stop keeps request high
    cyc(1'b1, 50, 100 * 64, 40 * 64, 200000);
    cyc(1'b1, 50, 100 * 64, 40 * 64, 200000);
    cyc(1'b1, 10, 100 * 64, 40 * 64, 200000);
    cyc(1'b1, 10, 100 * 64, 40 * 64, 200000);
    @(negedge clk);
    chk(m_tag, 32'(pause), 32'(m_pause));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule